// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a microcontroller bus address into one registered chip select. The targets are four equal code-memory blocks, a scratch SRAM, an internal I/O window and a peripheral I/O window. Software loads the base and length of each window, and a small control word, through a single register-write port. The address is sampled on a clock edge when the bus-cycle enable is high, and the matching select appears on the outputs after that edge.

The SRAM and I/O windows sit above the code space in priority. Where one of them covers code addresses, it takes those addresses, and the code underneath can no longer be reached. The block also checks the loaded configuration. A sticky error flag goes high when a write leaves two code windows sharing an address, or leaves two data/I/O windows sharing an address, or leaves a code window longer than its physical block. The block size and the bus width (byte or 16-bit word addressing) set that physical block size.

Top module: `memsel_decoder`

## Requirements
- R1: A window with non-zero length L at base B matches an address A when B <= A < B+L. A length of zero disables the window. Code window i drives cs_code[i], and the select is valid on the clock edge that samples A.
- R2: The control word sits at cfg_idx 7. Its bit 0 is the peripheral enable, bit 1 is the 16-bit mode, and bits 3:2 are the block-size code (0 = 8 KB, 1 = 16 KB, 2 or 3 = 32 KB). The capacity of a code block is that byte count in 8-bit mode and half of it, counted in words, in 16-bit mode. If a write leaves any code window longer than this capacity, cfg_err is set.
- R3: Window index 4 is the SRAM and drives cs_sram.
- R4: When the SRAM, internal I/O (index 5) or peripheral I/O (index 6) window matches, every code select is held low for that address.
- R5: At most one select is high in any cycle. When no window matches, all selects are low. Overlapping code windows resolve to the lowest index. Overlapping data windows resolve in the order SRAM, then internal I/O, then peripheral I/O.
- R6: An address sampled with bus_en low produces no select.
- R7: The peripheral window never matches while the peripheral enable is 0. While it is 0, it also takes no part in overlap checking.
- R8: If a write leaves two code windows that share an address, cfg_err is set.
- R9: If a write leaves two enabled data/I/O windows that share an address, cfg_err is set.
- R10: cfg_err goes high two edges after the offending write edge. It stays high until a stat_rd edge clears it. If a set and a clear fall on the same edge, the set wins.
- R11: After reset, all windows have length 0, the control word is 0, and all selects and cfg_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Valid bus cycle, qualifies decoding |
| addr | input | ADDR_W | Bus address in bus units (bytes or words) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window 0-6, or 7 for the control word |
| cfg_base | input | ADDR_W | Window base, or control bits in [3:0] |
| cfg_len | input | ADDR_W+1 | Window length, 0 disables |
| stat_rd | input | 1 | Status read, clears cfg_err |
| cs_code | output | 4 | Code block selects |
| cs_sram | output | 1 | SRAM select |
| cs_iio | output | 1 | Internal I/O select |
| cs_pio | output | 1 | Peripheral I/O select |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
A corrupted base or length register shows up on the next decoded cycle. The select moves to a neighbouring window or drops to none, exactly at a window edge, so the vectors probe both sides of every boundary and the shadowed code addresses. A wrong control bit changes either the gating of the peripheral window or the capacity limit. These are seen one cycle after the next probe address, or two edges after the next configuration write through cfg_err.

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_len,
  input  logic              stat_rd,
  output logic [3:0]        cs_code,
  output logic              cs_sram,
  output logic              cs_iio,
  output logic              cs_pio,
  output logic              cfg_err
);
  localparam int LW   = ADDR_W + 1;
  localparam int NWIN = 7;
  localparam int BLK_MIN = 8192;

  logic [ADDR_W-1:0] base_q [NWIN];
  logic [LW-1:0]     len_q  [NWIN];
  logic              pio_en, wide;
  logic [1:0]        blk;
  logic              wr_d;
  logic [NWIN-1:0]   hit;
  logic              cfg_bad;

  function automatic logic overlap(input logic [ADDR_W-1:0] b0, input logic [LW-1:0] l0,
                                   input logic [ADDR_W-1:0] b1, input logic [LW-1:0] l1);
    logic [LW:0] s0, s1, e0, e1;
    s0 = {2'b00, b0};
    s1 = {2'b00, b1};
    e0 = s0 + {1'b0, l0};
    e1 = s1 + {1'b0, l1};
    return (l0 != '0) && (l1 != '0) && (s0 < e1) && (s1 < e0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
      pio_en <= 1'b0;
      wide   <= 1'b0;
      blk    <= 2'd0;
      wr_d   <= 1'b0;
    end else begin
      wr_d <= cfg_we;
      if (cfg_we) begin
        if (cfg_idx == 3'd7) begin
          pio_en <= cfg_base[0];
          wide   <= cfg_base[1];
          blk    <= cfg_base[3:2];
        end else begin
          base_q[cfg_idx] <= cfg_base;
          len_q[cfg_idx]  <= cfg_len;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NWIN; i++)
      hit[i] = bus_en && (len_q[i] != '0) && (addr >= base_q[i]) &&
               ({1'b0, addr - base_q[i]} < len_q[i]);
    hit[6] = hit[6] & pio_en;
  end

  wire       data_any = |hit[6:4];
  wire [3:0] code_hit = hit[3:0];
  wire [3:0] code_win = data_any ? 4'b0 : (code_hit & (~code_hit + 4'd1));

  always_comb begin
    logic [31:0] cap;
    cap = (32'(BLK_MIN) << ((blk == 2'd3) ? 2'd2 : blk)) >> wide;
    cfg_bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (32'(len_q[i]) > cap) cfg_bad = 1'b1;
      for (int j = i + 1; j < 4; j++)
        if (overlap(base_q[i], len_q[i], base_q[j], len_q[j])) cfg_bad = 1'b1;
    end
    if (overlap(base_q[4], len_q[4], base_q[5], len_q[5])) cfg_bad = 1'b1;
    if (pio_en && overlap(base_q[4], len_q[4], base_q[6], len_q[6])) cfg_bad = 1'b1;
    if (pio_en && overlap(base_q[5], len_q[5], base_q[6], len_q[6])) cfg_bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_code <= '0;
      cs_sram <= 1'b0;
      cs_iio  <= 1'b0;
      cs_pio  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cs_code <= code_win;
      cs_sram <= hit[4];
      cs_iio  <= hit[5] & ~hit[4];
      cs_pio  <= hit[6] & ~hit[5] & ~hit[4];
      if (wr_d && cfg_bad)  cfg_err <= 1'b1;
      else if (stat_rd)     cfg_err <= 1'b0;
    end
  end
endmodule

module memsel_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       cfg_we,
  input logic       stat_rd,
  input logic       pio_en,
  input logic [3:0] cs_code,
  input logic       cs_sram,
  input logic       cs_iio,
  input logic       cs_pio,
  input logic       cfg_err
);
  wire [6:0] sel = {cs_pio, cs_iio, cs_sram, cs_code};

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) !bus_en |=> (sel == 7'd0));
  p_pio_gate_r7: assert property (@(posedge clk) disable iff (!rst_n) !pio_en |=> !cs_pio);
  p_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sram || cs_iio || cs_pio) |-> (cs_code == 4'd0));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !$past(cfg_we)) |=> !cfg_err);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !stat_rd) |=> cfg_err);
endmodule

bind memsel_decoder memsel_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cfg_we(cfg_we), .stat_rd(stat_rd),
  .pio_en(pio_en), .cs_code(cs_code), .cs_sram(cs_sram), .cs_iio(cs_iio),
  .cs_pio(cs_pio), .cfg_err(cfg_err)
);

// File: tb/tb_memsel_decoder.sv
module tb_memsel_decoder;
  localparam int AW = 17;
  logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, cfg_we = 1'b0, stat_rd = 1'b0;
  logic [AW-1:0] addr = '0, cfg_base = '0;
  logic [AW:0]   cfg_len = '0;
  logic [2:0]    cfg_idx = '0;
  logic [3:0]    cs_code;
  logic          cs_sram, cs_iio, cs_pio, cfg_err;
  int            nchk = 0, nbad = 0;

  always #2 clk = ~clk;

  memsel_decoder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .addr(addr), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_len(cfg_len), .stat_rd(stat_rd),
    .cs_code(cs_code), .cs_sram(cs_sram), .cs_iio(cs_iio), .cs_pio(cs_pio),
    .cfg_err(cfg_err)
  );

  wire [6:0] sel = {cs_pio, cs_iio, cs_sram, cs_code};

  // {bus_en, addr, expected {pio,iio,sram,code3..0}}
  localparam logic [24:0] VEC [15] = '{
    {1'b1, 17'h00000, 7'b0000001}, // R1 code0
    {1'b1, 17'h00FFF, 7'b0000001}, // R1
    {1'b1, 17'h01000, 7'b0010000}, // R3 R4 sram over code0
    {1'b1, 17'h017FF, 7'b0010000}, // R3
    {1'b1, 17'h01800, 7'b0000001}, // R1 edge above sram
    {1'b1, 17'h02000, 7'b0000010}, // R1 code1
    {1'b1, 17'h05000, 7'b0100000}, // R4 iio over code2
    {1'b1, 17'h050FF, 7'b0100000}, // R4
    {1'b1, 17'h05100, 7'b0000100}, // R1 code2
    {1'b1, 17'h06000, 7'b0001000}, // R1 code3
    {1'b1, 17'h07000, 7'b1000000}, // R4 pio over code3
    {1'b1, 17'h07200, 7'b0001000}, // R1
    {1'b1, 17'h08000, 7'b0000000}, // R5 no match
    {1'b1, 17'h1FFFF, 7'b0000000}, // R5
    {1'b0, 17'h00000, 7'b0000000}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [AW-1:0] b, input logic [AW:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_len = l;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a, output logic [6:0] s);
    @(negedge clk); bus_en = 1'b1; addr = a;
    @(negedge clk); s = sel; bus_en = 1'b0;
  endtask

  initial begin
    logic [6:0] s;
    repeat (3) @(negedge clk);
    chk("R11 selects after reset", 32'(sel), 0);
    chk("R11 err after reset", 32'(cfg_err), 0);
    rst_n = 1'b1;
    probe(17'h00000, s);
    chk("R11 no window enabled", 32'(s), 0);

    wr(7, 17'h1, 0);
    wr(0, 17'h0000, 18'h2000);
    wr(1, 17'h2000, 18'h2000);
    wr(2, 17'h4000, 18'h2000);
    wr(3, 17'h6000, 18'h2000);
    wr(4, 17'h1000, 18'h0800);
    wr(5, 17'h5000, 18'h0100);
    wr(6, 17'h7000, 18'h0200);
    chk("R8 R9 legal config no error", 32'(cfg_err), 0);

    foreach (VEC[i]) begin
      @(negedge clk);
      bus_en = VEC[i][24]; addr = VEC[i][23:7];
      @(negedge clk);
      chk($sformatf("R1 R3 R4 R5 R6 vector %0d", i), 32'(sel), 32'(VEC[i][6:0]));
    end
    bus_en = 1'b0;

    wr(7, 17'h0, 0);
    probe(17'h07000, s);
    chk("R7 pio disabled falls to code3", 32'(s), 32'h08);
    wr(7, 17'h1, 0);
    probe(17'h07000, s);
    chk("R7 pio enabled", 32'(s), 32'h40);

    wr(1, 17'h2000, 18'h2001);
    chk("R2 oversize code window", 32'(cfg_err), 1);
    @(negedge clk);
    chk("R10 sticky without read", 32'(cfg_err), 1);
    clr();
    chk("R10 cleared by read", 32'(cfg_err), 0);
    wr(1, 17'h2000, 18'h2000);
    chk("R10 legal write keeps clear", 32'(cfg_err), 0);

    wr(1, 17'h1F00, 18'h2000);
    chk("R8 code overlap", 32'(cfg_err), 1);
    probe(17'h1F80, s);
    chk("R5 code overlap lowest index", 32'(s), 32'h01);
    clr();
    wr(1, 17'h2000, 18'h2000);

    wr(5, 17'h1400, 18'h0100);
    chk("R9 sram iio overlap", 32'(cfg_err), 1);
    probe(17'h1400, s);
    chk("R5 sram beats iio", 32'(s), 32'h10);
    clr();
    wr(5, 17'h5000, 18'h0100);

    wr(7, 17'h0, 0);
    wr(6, 17'h1000, 18'h0100);
    chk("R7 disabled pio ignored in overlap", 32'(cfg_err), 0);
    wr(7, 17'h1, 0);
    chk("R9 pio overlap once enabled", 32'(cfg_err), 1);
    clr();
    wr(6, 17'h7000, 18'h0200);

    wr(7, 17'h3, 0);
    chk("R2 16-bit mode halves capacity", 32'(cfg_err), 1);
    clr();
    wr(7, 17'hB, 0);
    chk("R2 32K block in 16-bit mode fits", 32'(cfg_err), 0);
    wr(7, 17'h5, 0);
    chk("R2 16K block in 8-bit mode fits", 32'(cfg_err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule